// File: doc/BRIEF.md
# Atomic Acquire/Release Ordering Gate

This block sits between the memory issue stage of an in-order hart and a memory system that can hold several requests in flight. Every request carries a domain bit (memory or I/O), an operation class and, for atomic operations, an acquire flag and a release flag. The gate decides in each cycle whether the request at its input may go on. It decides from those flags and from what is still outstanding in the same domain.

It keeps a small count of outstanding requests for each domain. It also keeps a flag for each domain that marks an acquire atomic as in flight. A release atomic waits until its own domain has drained. An acquire atomic blocks later traffic to its domain until the memory system reports that the acquire has completed. The other domain is never held. The gate stalls a request only by holding its ready output low. The issuing stage keeps the request fields stable until the request is accepted.

Top module: `atomic_order_gate`

## Requirements
- R1: After a synchronous active-low reset, both outstanding counts are zero and no acquire is pending. A release atomic in either domain is therefore accepted at once.
- R2: A plain access (class 0) and an atomic with both flags clear are accepted whenever `mem_ready` is high, no acquire is pending in their domain and their domain count is below its maximum. `mem_valid` equals `req_valid` in that case.
- R3: After an atomic issues with only the acquire flag set, no further request to that domain is accepted. This lasts up to and including the cycle in which that domain's completion pulse arrives with `cmp_acq` set. An acquire-only atomic does not wait for earlier requests.
- R4: An atomic with only the release flag set is held while its domain has any outstanding request. It is accepted in the first cycle in which the count is zero.
- R5: An atomic with both flags set waits for its domain to drain and then blocks later requests to that domain until its acquire completion.
- R6: Outstanding requests and a pending acquire in one domain never stall a request to the other domain.
- R7: A load-reserved (class 2) with only the release flag set, and a store-conditional (class 3) with only the acquire flag set, are treated as unordered. They neither wait for a drain nor set an acquire pending. Class 1 is a read-modify-write atomic.
- R8: Each domain count is CNT_W bits wide. Issue is added to the count and a completion pulse is subtracted from it. At the maximum value (15 by default) further issue to that domain stalls until a completion arrives.
- R9: A blocked request sees `req_ready` low and `mem_valid` low. A request accepted in a cycle is counted exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present from the issue stage |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_dom | input | 1 | Target domain: 0 memory, 1 I/O |
| req_op | input | 2 | Class: 0 plain, 1 read-modify-write atomic, 2 load-reserved, 3 store-conditional |
| req_aq | input | 1 | Acquire flag |
| req_rl | input | 1 | Release flag |
| mem_valid | output | 1 | Request forwarded to the memory system |
| mem_ready | input | 1 | Memory system can take a request |
| cmp_pulse | input | 2 | One completion per domain this cycle (bit 0 memory, bit 1 I/O) |
| cmp_acq | input | 2 | The completing request of that domain is the pending acquire |

## Verification
The bench mixes acquire, release and combined atomics, and lets completions arrive in the same cycles as blocked requests. A gate that reads the count or the acquire flag one cycle late would then release a request too early or too late. It parks a release atomic in one domain while the other domain carries traffic, so a gate that shares state across domains stalls the wrong side. It sends a load-reserved with only release set and a store-conditional with only acquire set. A gate that honours those flags would drain or block where it should not. It also fills one domain to its maximum count, which shows whether a counter wraps to zero instead of stalling.

// File: rtl/aog_pkg.sv
// Shared types for the atomic ordering gate.
// Assumes a two-bit operation class field on every request.
package aog_pkg;
    typedef enum logic [1:0] {
        OP_PLAIN = 2'd0,
        OP_RMW   = 2'd1,
        OP_LDRES = 2'd2,
        OP_STCND = 2'd3
    } op_class_e;
endpackage

// File: rtl/aog_classify.sv
// Turns a request's class and flag bits into its ordering needs.
// Assumes flags on a plain access carry no meaning.
module aog_classify
    import aog_pkg::*;
(
    input  logic [1:0] op,
    input  logic       aq,
    input  logic       rl,
    output logic       needs_drain,
    output logic       sets_acquire
);
    logic is_atomic;
    logic rl_only_ldres;
    logic aq_only_stcnd;

    // Decode the class and drop the weak flag combinations.
    always_comb begin
        is_atomic     = (op != OP_PLAIN);
        rl_only_ldres = (op == OP_LDRES) && rl && !aq;
        aq_only_stcnd = (op == OP_STCND) && aq && !rl;
        needs_drain   = is_atomic && rl && !rl_only_ldres;
        sets_acquire  = is_atomic && aq && !aq_only_stcnd;
    end
endmodule

// File: rtl/aog_dom_track.sv
// Outstanding-request count and acquire-pending flag for one domain.
// Assumes the caller never increments when full or while an acquire
// is pending, and never sees a completion with nothing outstanding.
module aog_dom_track #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    input  logic set_acq,
    input  logic clr_acq,
    output logic is_zero,
    output logic is_full,
    output logic acq_pend
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;

    // Count issues up and completions down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Track the acquire that is in flight in this domain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acq_pend <= 1'b0;
        else if (set_acq)
            acq_pend <= 1'b1;
        else if (clr_acq)
            acq_pend <= 1'b0;
    end

    // Flag the count limits for the issue check.
    always_comb begin
        is_zero = (cnt == '0);
        is_full = (cnt == CNT_MAX);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        is_full |-> !inc);                                       // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !is_zero);                                       // R9
    AST_ACQ_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        acq_pend |-> !inc);                                      // R3
    AST_ACQ_FROM_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acq_pend) |-> $past(set_acq));                     // R5
endmodule

// File: rtl/atomic_order_gate.sv
// Issue gate that orders atomic operations by their acquire and release
// flags, separately for the memory and the I/O domain.
// Assumes the issue stage holds the request fields until accepted and
// that completions report which domain finished, and whether the
// finishing request was the pending acquire.
module atomic_order_gate #(
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_dom,
    input  logic [1:0] req_op,
    input  logic       req_aq,
    input  logic       req_rl,
    output logic       mem_valid,
    input  logic       mem_ready,
    input  logic [1:0] cmp_pulse,
    input  logic [1:0] cmp_acq
);
    localparam int NDOM = 2;

    logic            needs_drain;
    logic            sets_acquire;
    logic            allowed;
    logic            fire;
    logic [NDOM-1:0] dom_zero;
    logic [NDOM-1:0] dom_full;
    logic [NDOM-1:0] dom_acq;
    logic [NDOM-1:0] dom_inc;
    logic [NDOM-1:0] dom_set;
    logic [NDOM-1:0] dom_clr;

    aog_classify u_class (
        .op           (req_op),
        .aq           (req_aq),
        .rl           (req_rl),
        .needs_drain  (needs_drain),
        .sets_acquire (sets_acquire)
    );

    // Decide whether the present request may leave in this cycle.
    always_comb begin
        allowed   = !dom_acq[req_dom] && !dom_full[req_dom]
                    && (!needs_drain || dom_zero[req_dom]);
        req_ready = allowed && mem_ready;
        mem_valid = req_valid && allowed;
        fire      = req_valid && req_ready;
    end

    // Steer the handshake and completions to the matching domain.
    always_comb begin
        for (int d = 0; d < NDOM; d++) begin
            dom_inc[d] = fire && (req_dom == d[0]);
            dom_set[d] = dom_inc[d] && sets_acquire;
            dom_clr[d] = cmp_pulse[d] && cmp_acq[d];
        end
    end

    for (genvar g = 0; g < NDOM; g++) begin : g_dom
        aog_dom_track #(.CNT_W(CNT_W)) u_track (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (dom_inc[g]),
            .dec      (cmp_pulse[g]),
            .set_acq  (dom_set[g]),
            .clr_acq  (dom_clr[g]),
            .is_zero  (dom_zero[g]),
            .is_full  (dom_full[g]),
            .acq_pend (dom_acq[g])
        );
    end

    AST_RL_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && needs_drain) |-> dom_zero[req_dom]);       // R4
    AST_ACQ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dom_acq[req_dom]) |-> !req_ready);         // R3
    AST_STALL_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_valid) |-> !req_ready);               // R9
    AST_ONE_DOMAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dom_inc));                                      // R6
endmodule

// File: tb/atomic_order_gate_test.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset and saturation.
module atomic_order_gate_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_dom = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic       req_aq = 1'b0;
    logic       req_rl = 1'b0;
    logic       mem_valid;
    logic       mem_ready = 1'b1;
    logic [1:0] cmp_pulse = 2'b00;
    logic [1:0] cmp_acq = 2'b00;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    atomic_order_gate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_dom(req_dom), .req_op(req_op), .req_aq(req_aq), .req_rl(req_rl),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .cmp_pulse(cmp_pulse), .cmp_acq(cmp_acq)
    );

    // Row: [14:11] requirement, [10:9] completions {io,mem}, [8:7] acquire
    // marks, [6] valid, [5] domain, [4:3] class, [2] aq, [1] rl, [0] ready.
    localparam int NV = 25;
    localparam logic [14:0] VEC [NV] = '{
        15'b0010_00_00_1_0_00_0_0_1, // R2 plain mem, mem=1
        15'b0010_00_00_1_1_00_0_0_1, // R2 plain io, io=1
        15'b0100_00_00_1_0_01_0_1_0, // R4 release waits, mem=1
        15'b0100_01_00_1_0_01_0_1_0, // R4 completion same cycle, still held
        15'b0100_00_00_1_0_01_0_1_1, // R4 drained, accepted, mem=1
        15'b0011_01_00_1_0_01_1_0_1, // R3 acquire-only does not wait
        15'b0011_00_00_1_0_00_0_0_0, // R3 held behind acquire
        15'b0110_00_00_1_1_00_0_0_1, // R6 io unaffected, io=2
        15'b0011_01_01_1_0_00_0_0_0, // R3 acquire completes this cycle
        15'b0011_00_00_1_0_00_0_0_1, // R3 released, mem=1
        15'b0111_00_00_1_0_10_0_1_1, // R7 load-reserved rl only, mem=2
        15'b0111_00_00_1_0_11_1_0_1, // R7 store-conditional aq only, mem=3
        15'b0111_00_00_1_0_00_0_0_1, // R7 no acquire left pending, mem=4
        15'b0101_00_00_1_0_01_1_1_0, // R5 waits for drain (4)
        15'b0101_01_00_1_0_01_1_1_0, // R5 (4->3)
        15'b0101_01_00_1_0_01_1_1_0, // R5 (3->2)
        15'b0101_01_00_1_0_01_1_1_0, // R5 (2->1)
        15'b0101_01_00_1_0_01_1_1_0, // R5 (1->0)
        15'b0101_00_00_1_0_01_1_1_1, // R5 accepted, mem=1 pending
        15'b0101_00_00_1_0_00_0_0_0, // R5 blocks later mem
        15'b0110_10_00_1_1_01_0_1_0, // R6 io release waits (2->1)
        15'b0110_10_00_1_1_01_0_1_0, // R6 io (1->0)
        15'b0110_00_00_1_1_01_0_1_1, // R6 io release goes during mem acquire
        15'b0101_11_01_1_0_00_0_0_0, // R5 acquire completion cycle
        15'b0101_00_00_1_0_00_0_0_1  // R5 mem open again
    };

    task automatic check(input string rq, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic drive(input logic v, input logic d, input logic [1:0] op,
                         input logic aq, input logic rl,
                         input logic [1:0] cp, input logic [1:0] ca);
        req_valid = v; req_dom = d; req_op = op; req_aq = aq; req_rl = rl;
        cmp_pulse = cp; cmp_acq = ca;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: release atomics in both domains accepted right after reset.
        drive(1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 2'b00, 2'b00);
        #2; check("R1 mem ready", req_ready, 1'b1);
        req_dom = 1'b1;
        #1; check("R1 io ready", req_ready, 1'b1);
        req_valid = 1'b0;
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][6], VEC[i][5], VEC[i][4:3], VEC[i][2], VEC[i][1],
                  VEC[i][10:9], VEC[i][8:7]);
            #2;
            n_chk++;
            if (req_ready !== VEC[i][0] || mem_valid !== VEC[i][0]) begin
                n_bad++;
                $display("FAIL R%0d row %0d: ready %0b valid %0b expected %0b",
                         VEC[i][14:11], i, req_ready, mem_valid, VEC[i][0]);
            end
        end
        // Table leaves mem=1, io=0, nothing pending.

        // R8: fill io to 15, then the 16th must stall.
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            drive(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'b00, 2'b00);
            #2; check("R8 fill", req_ready, 1'b1);
        end
        @(negedge clk);
        #2;
        check("R8 full ready", req_ready, 1'b0);
        check("R9 full mem_valid", mem_valid, 1'b0);
        req_dom = 1'b0;
        #1; check("R6 mem open while io full", req_ready, 1'b1);
        req_dom = 1'b1;
        // R9: memory back-pressure only lowers ready; nothing counted.
        @(negedge clk);
        drive(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'b10, 2'b00);
        mem_ready = 1'b0;
        #2;
        check("R9 back-pressure ready", req_ready, 1'b0);
        check("R8 full still", mem_valid, 1'b0);
        @(negedge clk);
        drive(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'b00, 2'b00);
        #2;
        check("R9 valid under back-pressure", mem_valid, 1'b1);
        check("R9 ready under back-pressure", req_ready, 1'b0);
        mem_ready = 1'b1;
        #1; check("R8 one slot after completion", req_ready, 1'b1);
        @(negedge clk);
        #2; check("R8 full again", req_ready, 1'b0);

        // R1: mid-run reset clears both counts.
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 2'b00, 2'b00);
        #2; check("R1 io drained after reset", req_ready, 1'b1);
        req_dom = 1'b0;
        #1; check("R1 mem drained after reset", req_ready, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule